// File: doc/BRIEF.md
# Boot Source Latch and Address-Zero Remapper

This block decides, once per start-up, which memory the processor sees at address zero. It watches a board-level boot strap pin and a stored option bit. On a fixed clock edge counted from the release of reset, it captures both values. It then decodes them into one of three boot sources: main flash, system memory or embedded SRAM. The decoded source drives a remap select that steers the address-zero alias toward the chosen memory.

Once the source is fixed, the block performs the two start-up reads a processor needs. The first read, at address 0, returns the initial stack value. The second read, at address 4, returns the reset vector. Both reads go through the alias, and the block keeps both words. Only after the second read does it raise the release output that lets the processor run. A standby-exit event starts the same capture-and-fetch sequence again and holds the processor back until that sequence has finished.

The three memories are modelled by stubs. Each stub returns a word that identifies its memory and the address that was read, so a wrong alias is easy to spot.

Top module: `boot_remap_ctrl`

## Requirements
- R1: While reset is asserted, remap_sel_o is 2'b00 (flash), cpu_release_o and fetch_valid_o are 0, and fetch_addr_o, init_sp_o and init_pc_o are zero.
- R2: The configuration is captured on the 4th rising clock edge after reset is released. Before that edge, remap_sel_o holds 2'b00 and cpu_release_o stays low.
- R3: If the captured pin value is 0, remap_sel_o becomes 2'b00 (flash), whatever the option bit holds.
- R4: If the captured pin value is 1 and the option bit is 1, remap_sel_o becomes 2'b01 (system memory).
- R5: If the captured pin value is 1 and the option bit is 0, remap_sel_o becomes 2'b10 (SRAM). The encoding 2'b11 never appears.
- R6: For the cycle after the capture edge, fetch_valid_o is 1 with fetch_addr_o = 0. For the cycle after that, fetch_valid_o is 1 with fetch_addr_o = 4. At all other times fetch_valid_o is 0 and fetch_addr_o is 0.
- R7: init_sp_o takes the aliased word read at address 0, and init_pc_o takes the word read at address 4. A stub word is laid out as follows:
  - bits 31:24 hold 8'hB0 plus the source code;
  - bits 23:16 are zero;
  - bits 15:0 hold the address read.
- R8: cpu_release_o rises in the cycle after the address-4 read. It then stays high until reset or a standby exit.
- R9: A standby_exit_i pulse sampled on an edge does three things:
  - it drops cpu_release_o at that edge;
  - it starts a new count, and the configuration is captured again on the 4th following edge;
  - remap_sel_o keeps its old value until that capture.
- R10: Pin or option changes after the capture edge have no effect on remap_sel_o until the next capture.
- R11: The pin passes through two synchroniser flops. The value captured is therefore the pin as it stood at the 2nd edge of the count. A change after that edge is not seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| boot_pin_i | input | 1 | Boot strap pin, asynchronous |
| boot_opt_i | input | 1 | Stored boot option bit, static |
| standby_exit_i | input | 1 | One-cycle pulse on leaving standby |
| remap_sel_o | output | 2 | Address-zero alias: 00 flash, 01 system memory, 10 SRAM |
| fetch_valid_o | output | 1 | A start-up read is in progress |
| fetch_addr_o | output | ADDR_W | Address of the start-up read |
| init_sp_o | output | DATA_W | Word read at address 0 |
| init_pc_o | output | DATA_W | Word read at address 4 |
| cpu_release_o | output | 1 | Lets the processor run |

## Verification
Suppose the edge counter were off by one. The alias would then change one cycle early or late, and the pin-timing cases would latch a different pin value, so the remap output is wrong within five cycles of reset or standby exit. A wrong decode or a wrong alias shows within two further cycles: the top byte of the captured stack word and vector word carries the source code. A sequencer that skipped a read, or that failed to restart after standby, gives a release edge at the wrong time, and the bench reference model catches it on the next compare.

// File: rtl/boot_remap_pkg.sv
package boot_remap_pkg;

  typedef enum logic [1:0] {
    SRC_FLASH  = 2'b00,
    SRC_SYSMEM = 2'b01,
    SRC_SRAM   = 2'b10
  } boot_src_e;

  typedef enum logic [1:0] {
    PH_COUNT    = 2'b00,
    PH_FETCH_SP = 2'b01,
    PH_FETCH_PC = 2'b10,
    PH_RUN      = 2'b11
  } boot_phase_e;

  localparam int NUM_SRC = 3;
  localparam logic [7:0] STUB_TAG_BASE = 8'hB0;

  // Pin 0 selects flash whatever the option; pin 1 lets the option pick.
  function automatic boot_src_e decode_boot(input logic pin, input logic opt);
    if (!pin)     return SRC_FLASH;
    else if (opt) return SRC_SYSMEM;
    else          return SRC_SRAM;
  endfunction

endpackage

// File: rtl/boot_pin_sync.sv
module boot_pin_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_i,
  output logic sync_o
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], async_i};
  end

  assign sync_o = chain_q[STAGES-1];
endmodule

// File: rtl/boot_mem_stub.sv
module boot_mem_stub #(
  parameter int SRC    = 0,
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32
) (
  input  logic [ADDR_W-1:0] addr_i,
  output logic [DATA_W-1:0] rdata_o
);
  import boot_remap_pkg::*;

  localparam int PAD_W = DATA_W - 24;
  localparam logic [7:0] TAG = STUB_TAG_BASE + 8'(SRC);

  // Bit 0 also folds in any address bit above 15, so every address bit is used.
  function automatic logic [15:0] low_field(input logic [ADDR_W-1:0] a);
    return a[15:0] | {15'b0, |a[ADDR_W-1:16]};
  endfunction

  assign rdata_o = {TAG, {PAD_W{1'b0}}, low_field(addr_i)};
endmodule

// File: rtl/boot_seq.sv
module boot_seq #(
  parameter int SAMPLE_EDGE = 4,
  parameter int ADDR_W      = 32,
  parameter int DATA_W      = 32,
  parameter int VEC_STRIDE  = 4
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    pin_sync_i,
  input  logic                    opt_i,
  input  logic                    standby_exit_i,
  input  logic [DATA_W-1:0]       rdata_i,
  output boot_remap_pkg::boot_src_e sel_o,
  output logic                    fetch_valid_o,
  output logic [ADDR_W-1:0]       fetch_addr_o,
  output logic [DATA_W-1:0]       init_sp_o,
  output logic [DATA_W-1:0]       init_pc_o,
  output logic                    release_o,
  output logic                    latch_stb_o
);
  import boot_remap_pkg::*;

  localparam int CNT_W = $clog2(SAMPLE_EDGE + 1);
  localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(SAMPLE_EDGE - 1);

  logic [CNT_W-1:0]  cnt_q;
  boot_phase_e       ph_q;
  boot_src_e         sel_q;
  logic [DATA_W-1:0] sp_q, pc_q;

  assign latch_stb_o = !standby_exit_i && (ph_q == PH_COUNT) && (cnt_q == LAST_CNT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      ph_q  <= PH_COUNT;
      sel_q <= SRC_FLASH;
      sp_q  <= '0;
      pc_q  <= '0;
    end else if (standby_exit_i) begin
      cnt_q <= '0;
      ph_q  <= PH_COUNT;
    end else begin
      unique case (ph_q)
        PH_COUNT: begin
          if (latch_stb_o) begin
            sel_q <= decode_boot(pin_sync_i, opt_i);
            ph_q  <= PH_FETCH_SP;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        PH_FETCH_SP: begin
          sp_q <= rdata_i;
          ph_q <= PH_FETCH_PC;
        end
        PH_FETCH_PC: begin
          pc_q <= rdata_i;
          ph_q <= PH_RUN;
        end
        default: ph_q <= PH_RUN;
      endcase
    end
  end

  assign sel_o         = sel_q;
  assign fetch_valid_o = (ph_q == PH_FETCH_SP) || (ph_q == PH_FETCH_PC);
  assign fetch_addr_o  = (ph_q == PH_FETCH_PC) ? ADDR_W'(VEC_STRIDE) : '0;
  assign init_sp_o     = sp_q;
  assign init_pc_o     = pc_q;
  assign release_o     = (ph_q == PH_RUN);
endmodule

// File: rtl/boot_remap_ctrl.sv
module boot_remap_ctrl #(
  parameter int ADDR_W      = 32,
  parameter int DATA_W      = 32,
  parameter int SAMPLE_EDGE = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              boot_pin_i,
  input  logic              boot_opt_i,
  input  logic              standby_exit_i,
  output logic [1:0]        remap_sel_o,
  output logic              fetch_valid_o,
  output logic [ADDR_W-1:0] fetch_addr_o,
  output logic [DATA_W-1:0] init_sp_o,
  output logic [DATA_W-1:0] init_pc_o,
  output logic              cpu_release_o
);
  import boot_remap_pkg::*;

  logic              pin_sync;
  logic              latch_stb;
  boot_src_e         sel;
  logic [DATA_W-1:0] alias_rdata;
  logic [DATA_W-1:0] stub_rdata [NUM_SRC];

  boot_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .async_i (boot_pin_i),
    .sync_o  (pin_sync)
  );

  boot_seq #(
    .SAMPLE_EDGE (SAMPLE_EDGE),
    .ADDR_W      (ADDR_W),
    .DATA_W      (DATA_W),
    .VEC_STRIDE  (4)
  ) u_seq (
    .clk            (clk),
    .rst_n          (rst_n),
    .pin_sync_i     (pin_sync),
    .opt_i          (boot_opt_i),
    .standby_exit_i (standby_exit_i),
    .rdata_i        (alias_rdata),
    .sel_o          (sel),
    .fetch_valid_o  (fetch_valid_o),
    .fetch_addr_o   (fetch_addr_o),
    .init_sp_o      (init_sp_o),
    .init_pc_o      (init_pc_o),
    .release_o      (cpu_release_o),
    .latch_stb_o    (latch_stb)
  );

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_stub
    boot_mem_stub #(.SRC(g), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_mem (
      .addr_i  (fetch_addr_o),
      .rdata_o (stub_rdata[g])
    );
  end

  // Address-zero alias: route the selected memory's read data.
  always_comb begin
    alias_rdata = stub_rdata[0];
    for (int i = 0; i < NUM_SRC; i++) begin
      if (sel == boot_src_e'(2'(i))) alias_rdata = stub_rdata[i];
    end
  end

  assign remap_sel_o = sel;
endmodule

// File: rtl/boot_remap_chk.sv
module boot_remap_chk #(
  parameter int ADDR_W      = 32,
  parameter int SAMPLE_EDGE = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              standby_exit_i,
  input logic              latch_stb,
  input logic [1:0]        remap_sel_o,
  input logic              fetch_valid_o,
  input logic [ADDR_W-1:0] fetch_addr_o,
  input logic              cpu_release_o
);
  localparam int CW = $clog2(SAMPLE_EDGE + 1);
  logic [CW-1:0] edge_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                            edge_cnt <= '0;
    else if (standby_exit_i)               edge_cnt <= '0;
    else if (edge_cnt < CW'(SAMPLE_EDGE))  edge_cnt <= edge_cnt + 1'b1;
  end

  AST_STROBE_ON_NTH_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    latch_stb |-> (edge_cnt == CW'(SAMPLE_EDGE - 1))); // R2
  AST_STROBE_WHILE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    latch_stb |-> (!cpu_release_o && !fetch_valid_o)); // R2
  AST_LEGAL_SEL: assert property (@(posedge clk) disable iff (!rst_n)
    remap_sel_o != 2'b11); // R5
  AST_SP_THEN_PC: assert property (@(posedge clk) disable iff (!rst_n)
    (fetch_valid_o && fetch_addr_o == '0 && !standby_exit_i)
      |=> (fetch_valid_o && fetch_addr_o == ADDR_W'(4))); // R6
  AST_RELEASE_AFTER_FETCH: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cpu_release_o) |-> $past(fetch_valid_o && fetch_addr_o == ADDR_W'(4))); // R8
  AST_RELEASE_NO_FETCH: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_release_o |-> !fetch_valid_o); // R8
  AST_STANDBY_HOLDS_CPU: assert property (@(posedge clk) disable iff (!rst_n)
    standby_exit_i |=> !cpu_release_o); // R9
  AST_SEL_ONLY_ON_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    !latch_stb |=> $stable(remap_sel_o)); // R10
endmodule

bind boot_remap_ctrl boot_remap_chk #(
  .ADDR_W      (ADDR_W),
  .SAMPLE_EDGE (SAMPLE_EDGE)
) u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .standby_exit_i (standby_exit_i),
  .latch_stb      (latch_stb),
  .remap_sel_o    (remap_sel_o),
  .fetch_valid_o  (fetch_valid_o),
  .fetch_addr_o   (fetch_addr_o),
  .cpu_release_o  (cpu_release_o)
);

// File: tb/tb_boot_remap_ctrl.sv
`timescale 1ns/1ps
module tb_boot_remap_ctrl;
  localparam int AW = 32;
  localparam int DW = 32;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic boot_pin = 1'b0;
  logic boot_opt = 1'b0;
  logic standby = 1'b0;
  logic [1:0]    remap_sel;
  logic          fetch_valid;
  logic [AW-1:0] fetch_addr;
  logic [DW-1:0] init_sp, init_pc;
  logic          cpu_release;

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  boot_remap_ctrl dut (
    .clk            (clk),
    .rst_n          (rst_n),
    .boot_pin_i     (boot_pin),
    .boot_opt_i     (boot_opt),
    .standby_exit_i (standby),
    .remap_sel_o    (remap_sel),
    .fetch_valid_o  (fetch_valid),
    .fetch_addr_o   (fetch_addr),
    .init_sp_o      (init_sp),
    .init_pc_o      (init_pc),
    .cpu_release_o  (cpu_release)
  );

  // Reference model: phase 0 counting, 1 stack read, 2 vector read, 3 running.
  int m_ph, m_cnt, m_sel;
  logic [31:0] m_sp, m_pc;
  bit pin_hist[$];

  function automatic int ref_source(bit pin, bit opt);
    if (pin && opt) return 1;
    if (pin)        return 2;
    return 0;
  endfunction

  function automatic logic [31:0] ref_word(int src, int a);
    return 32'hB000_0000 + (32'(src) << 24) + 32'(a);
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_ph = 0; m_cnt = 0; m_sel = 0; m_sp = 0; m_pc = 0;
      pin_hist.delete();
    end else begin
      pin_hist.push_front(boot_pin);
      if (pin_hist.size() > 3) void'(pin_hist.pop_back());
      if (standby) begin
        m_ph = 0; m_cnt = 0;
      end else if (m_ph == 0) begin
        m_cnt++;
        if (m_cnt == 4) begin
          m_sel = ref_source(pin_hist[2], boot_opt);
          m_ph = 1;
        end
      end else if (m_ph == 1) begin
        m_sp = ref_word(m_sel, 0); m_ph = 2;
      end else if (m_ph == 2) begin
        m_pc = ref_word(m_sel, 4); m_ph = 3;
      end
    end
  end

  task automatic check(string req, string what, longint act, longint exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h at %0t", req, what, act, exp, $time);
    end
  endtask

  // Compare against the model on every falling edge.
  always @(negedge clk) begin
    if (!finished) begin
      check("R2", "remap_sel", remap_sel, m_sel);
      check("R6", "fetch_valid", fetch_valid, (m_ph == 1 || m_ph == 2));
      check("R6", "fetch_addr", fetch_addr, (m_ph == 2) ? 4 : 0);
      check("R7", "init_sp", init_sp, m_sp);
      check("R7", "init_pc", init_pc, m_pc);
      check("R8", "cpu_release", cpu_release, (m_ph == 3));
    end
  end

  task automatic step(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic pulse_standby();
    standby = 1'b1;
    step(1);
    standby = 1'b0;
  endtask

  task automatic finish_run();
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired at %0t", $time);
    finish_run();
  end

  initial begin
    // Reset state
    step(2);
    @(negedge clk);
    check("R1", "reset remap", remap_sel, 0);
    check("R1", "reset release", cpu_release, 0);
    check("R1", "reset sp", init_sp, 0);

    // Pin 0, option 1 -> flash
    boot_pin = 1'b0; boot_opt = 1'b1;
    @(posedge clk); #1;
    rst_n = 1'b1;
    step(3);
    check("R2", "release before capture", cpu_release, 0);
    step(7);
    check("R3", "pin0 flash", remap_sel, 2'b00);
    check("R7", "flash stack word", init_sp, 32'hB000_0000);
    check("R8", "released", cpu_release, 1);

    // Standby exit, pin 1, option 1 -> system memory
    boot_pin = 1'b1;
    step(3);
    pulse_standby();
    check("R9", "release dropped", cpu_release, 0);
    check("R9", "remap kept before resample", remap_sel, 2'b00);
    step(10);
    check("R4", "sysmem", remap_sel, 2'b01);
    check("R7", "sysmem vector", init_pc, 32'hB100_0004);

    // Pin/option toggles after capture are ignored
    boot_pin = 1'b0; boot_opt = 1'b0;
    step(6);
    check("R10", "remap unchanged", remap_sel, 2'b01);

    // Pin 1, option 0 -> SRAM
    boot_pin = 1'b1;
    step(3);
    pulse_standby();
    step(10);
    check("R5", "sram", remap_sel, 2'b10);
    check("R7", "sram stack word", init_sp, 32'hB200_0000);

    // Pin rises after count edge 2: not seen, flash
    boot_pin = 1'b0; boot_opt = 1'b1;
    step(3);
    pulse_standby();
    step(2);
    boot_pin = 1'b1;
    step(10);
    check("R11", "late pin ignored", remap_sel, 2'b00);

    // Pin rises after count edge 1: seen at edge 2, system memory
    boot_pin = 1'b0;
    step(3);
    pulse_standby();
    step(1);
    boot_pin = 1'b1;
    step(10);
    check("R11", "pin at edge2 seen", remap_sel, 2'b01);

    // Standby during the count restarts it
    boot_opt = 1'b0;
    pulse_standby();
    step(2);
    pulse_standby();
    step(3);
    check("R9", "no early capture", remap_sel, 2'b01);
    step(8);
    check("R9", "capture after restart", remap_sel, 2'b10);

    // Reset in the middle of the start-up reads
    pulse_standby();
    step(4);
    rst_n = 1'b0;
    #1;
    check("R1", "async reset remap", remap_sel, 0);
    check("R1", "async reset fetch", fetch_valid, 0);
    step(2);
    rst_n = 1'b1;
    step(12);
    check("R5", "sram after reset", remap_sel, 2'b10);

    finish_run();
  end
endmodule